// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the local interrupt sources of a four-core cluster and turns them into a normal-priority (IRQ) and a fast (FIQ) interrupt line for each core. Every core has four timer level inputs and four mailbox-active flags of its own. One GPU interrupt is shared by all cores, and each core has a performance-monitor level input. Software programs per-core enables through a small register window. Each source is sent either to the IRQ vector or to the FIQ vector. A fast enable always takes precedence over a normal enable for the same source, so no source ever appears in both vectors.

The shared GPU interrupt is steered to exactly one core for IRQ and one core for FIQ. Performance-monitor enables are changed only through separate write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed. The per-core pending vectors are readable at any time. They are combinational from the current source levels and the programmed enables.

The register port has no handshake. A write takes effect at the clock edge where `wr_en` is high. A read is a purely combinational function of `rd_addr`.

Top module: `core_irq_router`

## Requirements
- R1: After reset, every timer control, mailbox control, GPU routing and performance-monitor enable field reads back as zero. Both GPU selectors therefore name core 0, and an asserted `gpu_irq` appears only on `core_fiq[0]`.
- R2: The timer control of core c is at address 0x40+4c. Bits 3:0 are IRQ enables and bits 7:4 are FIQ enables for timers 0..3. Timer t of core c is input `tmr_lvl[4c+t]` and uses pending bit t. The timer is pending in FIQ when its FIQ enable is set. It is pending in IRQ when its IRQ enable is set and its FIQ enable is clear.
- R3: The mailbox control of core c is at address 0x50+4c and uses the same enable layout. Mailbox m of core c is input `mbx_act[4c+m]` and uses pending bit 4+m, with the same FIQ-over-IRQ rule.
- R4: The GPU routing register is at address 0x0C. Bits 1:0 select the IRQ core and bits 3:2 select the FIQ core. Reads return the four bits, zero-extended. An active `gpu_irq` sets FIQ pending bit 8 of the FIQ core. It sets IRQ pending bit 8 of the IRQ core only if that core differs from the FIQ core.
- R5: A write to 0x10 sets the performance-monitor enable of every core whose data bit in 3:0 is 1. A write to 0x14 clears those enables. Zero data bits leave the enables unchanged, and the mask reads back at 0x10. An enabled `pmu_lvl[c]` sets IRQ pending bit 9 of core c and never sets an FIQ pending bit.
- R6: The IRQ pending vector of core c reads at 0x60+4c and the FIQ pending vector at 0x70+4c. Writes to those addresses change nothing, and any unmapped address reads zero.
- R7: `core_irq[c]` is high exactly when any IRQ pending bit of core c is set. `core_fiq[c]` is high exactly when any FIQ pending bit of core c is set.
- R8: No pending bit of a core is set in its IRQ vector and its FIQ vector at the same time.
- R9: Timer and mailbox controls read back the eight bits last written. Control and routing state changes only through writes to their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Combinational read data |
| tmr_lvl | input | 16 | Timer levels, index 4*core+timer |
| mbx_act | input | 16 | Mailbox-active flags, index 4*core+mailbox |
| gpu_irq | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 4 | Per-core performance-monitor levels |
| core_irq | output | 4 | Per-core IRQ outputs |
| core_fiq | output | 4 | Per-core FIQ outputs |

## Verification
A corrupted enable, routing or mask bit shows up in the same cycle as a wrong pending bit and a wrong core line, provided the source that bit governs is active. A latent fault stays hidden until that source asserts. For that reason the bench drives random source levels every cycle alongside random writes. It also compares the core lines and the addressed read data with a behavioural model after every clock. A write that is misdecoded or misapplied becomes visible one clock after the write edge, either in the readback or on the core lines.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned N_TMR   = 4;
  localparam int unsigned N_MBX   = 4;
  localparam int unsigned PEND_W  = N_TMR + N_MBX + 2;
  localparam int unsigned BIT_MBX = N_TMR;
  localparam int unsigned BIT_GPU = N_TMR + N_MBX;
  localparam int unsigned BIT_PMU = BIT_GPU + 1;
  localparam int unsigned STRIDE  = 4;

  localparam logic [ADDR_W-1:0] OFS_ROUTE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PMU_SET = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PMU_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_TMR     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MBX     = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_IRQP    = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_FIQP    = 8'h70;

  // A source is normal-priority only while its fast enable is clear.
  function automatic logic [3:0] steer_irq(logic [3:0] lvl, logic [CTL_W-1:0] ctl);
    return lvl & ctl[3:0] & ~ctl[7:4];
  endfunction

  function automatic logic [3:0] steer_fiq(logic [3:0] lvl, logic [CTL_W-1:0] ctl);
    return lvl & ctl[7:4];
  endfunction

  // Address of the per-core slot idx inside a bank.
  function automatic logic hits_slot(logic [ADDR_W-1:0] addr, logic [ADDR_W-1:0] base,
                                     int unsigned idx);
    return addr == (base + ADDR_W'(idx * STRIDE));
  endfunction
endpackage

// File: rtl/core_irq_regs.sv
module core_irq_regs
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CSEL_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CTL_W-1:0]                 wr_data,
  output logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl,
  output logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl,
  output logic [CSEL_W-1:0]                irq_sel,
  output logic [CSEL_W-1:0]                fiq_sel,
  output logic [NUM_CORES-1:0]             pmu_en,
  output logic                             pmu_set_hit,
  output logic                             pmu_clr_hit
);
  logic route_hit;

  assign route_hit   = wr_en && (wr_addr == OFS_ROUTE);
  assign pmu_set_hit = wr_en && (wr_addr == OFS_PMU_SET);
  assign pmu_clr_hit = wr_en && (wr_addr == OFS_PMU_CLR);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic tmr_hit, mbx_hit;
    assign tmr_hit = wr_en && hits_slot(wr_addr, OFS_TMR, c);
    assign mbx_hit = wr_en && hits_slot(wr_addr, OFS_MBX, c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_ctl[c] <= '0;
        mbx_ctl[c] <= '0;
      end else begin
        if (tmr_hit) tmr_ctl[c] <= wr_data;
        if (mbx_hit) mbx_ctl[c] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sel <= '0;
      fiq_sel <= '0;
    end else if (route_hit) begin
      irq_sel <= wr_data[CSEL_W-1:0];
      fiq_sel <= wr_data[2*CSEL_W-1:CSEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmu_en <= '0;
    end else if (pmu_set_hit) begin
      pmu_en <= pmu_en | wr_data[NUM_CORES-1:0];
    end else if (pmu_clr_hit) begin
      pmu_en <= pmu_en & ~wr_data[NUM_CORES-1:0];
    end
  end
endmodule

// File: rtl/core_irq_lane.sv
module core_irq_lane
  import core_irq_pkg::*;
#(
  parameter int unsigned CORE_ID = 0,
  parameter int unsigned CSEL_W  = 2
) (
  input  logic [N_TMR-1:0]  tmr_lvl,
  input  logic [N_MBX-1:0]  mbx_act,
  input  logic [CTL_W-1:0]  tmr_ctl,
  input  logic [CTL_W-1:0]  mbx_ctl,
  input  logic              gpu_irq,
  input  logic [CSEL_W-1:0] irq_sel,
  input  logic [CSEL_W-1:0] fiq_sel,
  input  logic              pmu_lvl,
  input  logic              pmu_en,
  output logic [PEND_W-1:0] irq_pend,
  output logic [PEND_W-1:0] fiq_pend,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam logic [CSEL_W-1:0] ME = CSEL_W'(CORE_ID);

  logic gpu_fast_here, gpu_norm_here;

  // Fast routing wins when both selectors name this core.
  assign gpu_fast_here = gpu_irq && (fiq_sel == ME);
  assign gpu_norm_here = gpu_irq && (irq_sel == ME) && (fiq_sel != ME);

  always_comb begin
    irq_pend = '0;
    fiq_pend = '0;
    irq_pend[N_TMR-1:0]               = steer_irq(tmr_lvl, tmr_ctl);
    fiq_pend[N_TMR-1:0]               = steer_fiq(tmr_lvl, tmr_ctl);
    irq_pend[BIT_MBX +: N_MBX]        = steer_irq(mbx_act, mbx_ctl);
    fiq_pend[BIT_MBX +: N_MBX]        = steer_fiq(mbx_act, mbx_ctl);
    irq_pend[BIT_GPU]                 = gpu_norm_here;
    fiq_pend[BIT_GPU]                 = gpu_fast_here;
    irq_pend[BIT_PMU]                 = pmu_lvl && pmu_en;
  end

  assign irq_out = |irq_pend;
  assign fiq_out = |fiq_pend;
endmodule

// File: rtl/core_irq_rdmux.sv
module core_irq_rdmux
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CSEL_W    = 2,
  parameter int unsigned RDATA_W   = 32
) (
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl,
  input  logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl,
  input  logic [CSEL_W-1:0]                irq_sel,
  input  logic [CSEL_W-1:0]                fiq_sel,
  input  logic [NUM_CORES-1:0]             pmu_en,
  input  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend,
  input  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend,
  output logic [RDATA_W-1:0]               rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == OFS_ROUTE)   rd_data = RDATA_W'({fiq_sel, irq_sel});
    if (rd_addr == OFS_PMU_SET) rd_data = RDATA_W'(pmu_en);
    for (int c = 0; c < NUM_CORES; c++) begin
      if (hits_slot(rd_addr, OFS_TMR, c))  rd_data = RDATA_W'(tmr_ctl[c]);
      if (hits_slot(rd_addr, OFS_MBX, c))  rd_data = RDATA_W'(mbx_ctl[c]);
      if (hits_slot(rd_addr, OFS_IRQP, c)) rd_data = RDATA_W'(irq_pend[c]);
      if (hits_slot(rd_addr, OFS_FIQP, c)) rd_data = RDATA_W'(fiq_pend[c]);
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned RDATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CTL_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [RDATA_W-1:0]           rd_data,
  input  logic [NUM_CORES*N_TMR-1:0]   tmr_lvl,
  input  logic [NUM_CORES*N_MBX-1:0]   mbx_act,
  input  logic                         gpu_irq,
  input  logic [NUM_CORES-1:0]         pmu_lvl,
  output logic [NUM_CORES-1:0]         core_irq,
  output logic [NUM_CORES-1:0]         core_fiq
);
  localparam int unsigned CSEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl;
  logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl;
  logic [CSEL_W-1:0]                irq_sel;
  logic [CSEL_W-1:0]                fiq_sel;
  logic [NUM_CORES-1:0]             pmu_en;
  logic                             pmu_set_hit;
  logic                             pmu_clr_hit;
  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_all;
  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_all;

  core_irq_regs #(.NUM_CORES(NUM_CORES), .CSEL_W(CSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .irq_sel(irq_sel), .fiq_sel(fiq_sel),
    .pmu_en(pmu_en), .pmu_set_hit(pmu_set_hit), .pmu_clr_hit(pmu_clr_hit)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    core_irq_lane #(.CORE_ID(c), .CSEL_W(CSEL_W)) u_lane (
      .tmr_lvl(tmr_lvl[c*N_TMR +: N_TMR]),
      .mbx_act(mbx_act[c*N_MBX +: N_MBX]),
      .tmr_ctl(tmr_ctl[c]),
      .mbx_ctl(mbx_ctl[c]),
      .gpu_irq(gpu_irq),
      .irq_sel(irq_sel),
      .fiq_sel(fiq_sel),
      .pmu_lvl(pmu_lvl[c]),
      .pmu_en(pmu_en[c]),
      .irq_pend(irq_pend_all[c]),
      .fiq_pend(fiq_pend_all[c]),
      .irq_out(core_irq[c]),
      .fiq_out(core_fiq[c])
    );
  end

  core_irq_rdmux #(.NUM_CORES(NUM_CORES), .CSEL_W(CSEL_W), .RDATA_W(RDATA_W)) u_rdmux (
    .rd_addr(rd_addr), .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl),
    .irq_sel(irq_sel), .fiq_sel(fiq_sel), .pmu_en(pmu_en),
    .irq_pend(irq_pend_all), .fiq_pend(fiq_pend_all), .rd_data(rd_data)
  );
endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CSEL_W    = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [CTL_W-1:0]                 wr_data,
  input logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl,
  input logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl,
  input logic [CSEL_W-1:0]                irq_sel,
  input logic [CSEL_W-1:0]                fiq_sel,
  input logic [NUM_CORES-1:0]             pmu_en,
  input logic                             pmu_set_hit,
  input logic                             pmu_clr_hit,
  input logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_all,
  input logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_all
);
  logic [NUM_CORES-1:0] gpu_norm_col, gpu_fast_col;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      gpu_norm_col[c] = irq_pend_all[c][BIT_GPU];
      gpu_fast_col[c] = fiq_pend_all[c][BIT_GPU];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (irq_sel == '0 && fiq_sel == '0 && pmu_en == '0 && tmr_ctl == '0 && mbx_ctl == '0)); // R1

  AST_GPU_ONE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_norm_col)); // R4

  AST_GPU_ONE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_fast_col)); // R4

  AST_PMU_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_set_hit |=> pmu_en == ($past(pmu_en) | $past(wr_data[NUM_CORES-1:0]))); // R5

  AST_PMU_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_clr_hit |=> pmu_en == ($past(pmu_en) & ~$past(wr_data[NUM_CORES-1:0]))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tmr_ctl) && $stable(mbx_ctl) && $stable(irq_sel)
                && $stable(fiq_sel) && $stable(pmu_en))); // R9

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_all[c] & fiq_pend_all[c]) == '0); // R8
  end
endmodule

bind core_irq_router core_irq_router_chk #(.NUM_CORES(NUM_CORES), .CSEL_W(CSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .irq_sel(irq_sel), .fiq_sel(fiq_sel),
  .pmu_en(pmu_en), .pmu_set_hit(pmu_set_hit), .pmu_clr_hit(pmu_clr_hit),
  .irq_pend_all(irq_pend_all), .fiq_pend_all(fiq_pend_all)
);

// File: tb/core_irq_router_bench.sv
module core_irq_router_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [15:0] tmr_lvl = 0;
  logic [15:0] mbx_act = 0;
  logic        gpu_irq = 0;
  logic [3:0]  pmu_lvl = 0;
  logic [3:0]  core_irq, core_fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  core_irq_router u_core_irq_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_lvl(tmr_lvl), .mbx_act(mbx_act),
    .gpu_irq(gpu_irq), .pmu_lvl(pmu_lvl), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  always #5 clk = ~clk;

  // Behavioural reference state
  int m_tmr[4] = '{0, 0, 0, 0};
  int m_mbx[4] = '{0, 0, 0, 0};
  int m_route = 0;
  int m_pmu = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_tmr[i] <= 0; m_mbx[i] <= 0; end
      m_route <= 0; m_pmu <= 0;
    end else if (wr_en) begin
      int a; a = int'(wr_addr);
      if (a == 12) m_route <= int'(wr_data) % 16;
      else if (a == 16) m_pmu <= m_pmu | (int'(wr_data) % 16);
      else if (a == 20) m_pmu <= m_pmu & ~(int'(wr_data) % 16);
      else if (a >= 64 && a < 80 && a % 4 == 0) m_tmr[(a - 64) / 4] <= int'(wr_data);
      else if (a >= 80 && a < 96 && a % 4 == 0) m_mbx[(a - 80) / 4] <= int'(wr_data);
    end
  end

  function automatic int exp_pend(int core, bit fast);
    int v = 0;
    int irq_core = m_route % 4;
    int fiq_core = m_route / 4;
    for (int s = 0; s < 8; s++) begin
      int k = s % 4;
      bit lvl = (s < 4) ? tmr_lvl[core*4 + k] : mbx_act[core*4 + k];
      int ctl = (s < 4) ? m_tmr[core] : m_mbx[core];
      bit ien = ((ctl >> k) & 1) == 1;
      bit fen = ((ctl >> (k + 4)) & 1) == 1;
      if (fast ? (lvl && fen) : (lvl && ien && !fen)) v += (1 << s);
    end
    if (gpu_irq) begin
      if (fast && core == fiq_core) v += 256;
      if (!fast && core == irq_core && irq_core != fiq_core) v += 256;
    end
    if (!fast && pmu_lvl[core] && ((m_pmu >> core) & 1) == 1) v += 512;
    return v;
  endfunction

  function automatic int exp_read(int a);
    if (a == 12) return m_route;
    if (a == 16) return m_pmu;
    if (a % 4 != 0) return 0;
    if (a >= 64 && a < 80) return m_tmr[(a - 64) / 4];
    if (a >= 80 && a < 96) return m_mbx[(a - 80) / 4];
    if (a >= 96 && a < 112) return exp_pend((a - 96) / 4, 0);
    if (a >= 112 && a < 128) return exp_pend((a - 112) / 4, 1);
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        check("R7 core_irq", int'(core_irq[c]), int'(exp_pend(c, 0) != 0));
        check("R7 core_fiq", int'(core_fiq[c]), int'(exp_pend(c, 1) != 0));
      end
      check("R6/R9 rd_data", int'(rd_data), exp_read(int'(rd_addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string tag, input logic [7:0] a, input int exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values and GPU default routing
    rd_chk("R1 route", 8'h0C, 0);
    rd_chk("R1 pmu mask", 8'h10, 0);
    rd_chk("R1 tmr ctl core3", 8'h4C, 0);
    gpu_irq = 1;
    #1;
    check("R1 gpu to core0 fiq", int'(core_fiq), 1);
    check("R1 gpu not on irq", int'(core_irq), 0);
    gpu_irq = 0;

    // R2 timer steering, core 1 timer 0
    tmr_lvl[4] = 1;
    wr(8'h44, 8'h01);
    rd_chk("R2 irq pend core1", 8'h64, 32'h001);
    rd_chk("R2 fiq pend core1", 8'h74, 0);
    wr(8'h44, 8'h11);
    rd_chk("R2 fiq override irq", 8'h64, 0);
    rd_chk("R2 fiq pend core1", 8'h74, 32'h001);
    tmr_lvl[4] = 0;

    // R3 mailbox steering, core 2 mailbox 1 -> bit 5
    mbx_act[9] = 1;
    wr(8'h58, 8'h02);
    rd_chk("R3 irq pend core2", 8'h68, 32'h020);
    wr(8'h58, 8'h22);
    rd_chk("R3 fiq pend core2", 8'h78, 32'h020);
    rd_chk("R3 irq cleared core2", 8'h68, 0);
    mbx_act[9] = 0;

    // R4 GPU routing
    gpu_irq = 1;
    wr(8'h0C, 8'h0D);
    rd_chk("R4 route readback", 8'h0C, 32'hD);
    rd_chk("R4 gpu irq core1", 8'h64, 32'h100);
    rd_chk("R4 gpu fiq core3", 8'h7C, 32'h100);
    wr(8'h0C, 8'h05);
    rd_chk("R4 same core fiq", 8'h74, 32'h100);
    rd_chk("R4 same core no irq", 8'h64, 0);
    gpu_irq = 0;
    wr(8'h0C, 8'hFF);
    rd_chk("R4 route upper bits", 8'h0C, 32'hF);

    // R5 PMU set and clear
    pmu_lvl = 4'hF;
    wr(8'h10, 8'h05);
    rd_chk("R5 set mask", 8'h10, 5);
    wr(8'h14, 8'h04);
    rd_chk("R5 clear mask", 8'h10, 1);
    wr(8'h10, 8'h00);
    rd_chk("R5 zero set no effect", 8'h10, 1);
    wr(8'h14, 8'h00);
    rd_chk("R5 zero clear no effect", 8'h10, 1);
    rd_chk("R5 pmu irq core0", 8'h60, 32'h200);
    rd_chk("R5 pmu never fiq", 8'h70, 0);
    rd_chk("R5 pmu disabled core2", 8'h68, 0);
    pmu_lvl = 0;

    // R6 pending read-only, unmapped zero
    pmu_lvl[0] = 1;
    wr(8'h60, 8'hFF);
    wr(8'h70, 8'hFF);
    rd_chk("R6 irq pend unchanged", 8'h60, 32'h200);
    rd_chk("R6 fiq pend unchanged", 8'h70, 0);
    rd_chk("R6 unmapped", 8'h20, 0);
    rd_chk("R6 unaligned", 8'h41, 0);
    pmu_lvl = 0;

    // R9 control readback
    wr(8'h4C, 8'hA5);
    rd_chk("R9 tmr ctl core3", 8'h4C, 32'hA5);
    wr(8'h54, 8'h3C);
    rd_chk("R9 mbx ctl core1", 8'h54, 32'h3C);
    rd_chk("R9 neighbour untouched", 8'h50, 0);

    // Random phase, checked by the per-clock model comparison (R2 R3 R4 R5 R7 R8)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      tmr_lvl = 16'($urandom);
      mbx_act = 16'($urandom);
      gpu_irq = 1'($urandom);
      pmu_lvl = 4'($urandom);
      rd_addr = 8'($urandom_range(0, 31) * 4);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1;
        wr_addr = 8'($urandom_range(0, 31) * 4);
        wr_data = 8'($urandom);
      end else begin
        wr_en = 0;
      end
      #1;
      for (int c = 0; c < 4; c++)
        check("R8 no dual", exp_pend(c, 0) & exp_pend(c, 1), 0);
    end
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule